// File: doc/BRIEF.md
# System Control and Timekeeping Register Block

This block is a slave on a simple 32-bit little-endian register bus and decodes a 4 KB window. It holds the board-level odds and ends that firmware needs: a user LED register whose width is a build parameter, a read-as-written miscellaneous control word, an optional debug control word, read-only views of push buttons and (optionally) slide switches, and two free-running time counters that tick once per second and a hundred times per second. It also holds a prescaled event counter. That counter is a reload value, a down-counter that counts the prescaler clock, and a 32-bit event count that advances each time the down-counter reloads.

Software reaches every register with single-cycle accesses. A request is `busSel` high for one clock, with `busWr` choosing direction. Read data is registered and appears on `busRdata` one clock after the request. It then holds until the next read. An access to an offset with no register, or to an optional register that the build leaves out, returns zero and raises `busErr` for one clock.

The time counters are derived from the system clock by fractional accumulators, so any `CLK_HZ` works. The event counter's prescaler clock is the system clock divided by `PS_DIV`.

Top module: `sysctl_regs`

## Requirements
- R1: Registers sit at byte offsets LED 0x00, debug 0x04, buttons 0x08, 1 Hz count 0x10, 100 Hz count 0x14, event count 0x18, reload 0x1C, down-counter 0x20, switches 0x28 and misc 0x4C. A read requested at one clock edge delivers its data on `busRdata` after that edge, and `busRdata` holds its value while no read is requested.
- R2: A write to the LED register keeps only its low `NUM_LEDS` bits. Bit i drives `leds[i]` active high, and a read returns the stored bits zero-extended. The LED outputs change only on a write to offset 0x00.
- R3: The debug offset exists only when `HAS_DBG` is set, and the switch offset only when `HAS_SW` is set. Otherwise that offset behaves as unmapped.
- R4: A read from an unmapped or misaligned offset returns zero. Any access to such an offset pulses `busErr` for the one clock after the request. A write there changes no register. Mapped accesses never raise `busErr`.
- R5: The misc register, and the debug register when present, read back exactly the last 32-bit value written.
- R6: The 1 Hz and 100 Hz counters count whole periods of `CLK_HZ` and `CLK_HZ/100` clocks. A write loads the count and restarts the period phase, so t clocks after the write the counter reads value + floor(t*rate/`CLK_HZ`).
- R7: The down-counter decrements on each prescaler tick while it is nonzero. On a tick at zero it reloads from the reload register and the event count increments. Writes to the reload, down-counter and event count registers load them directly.
- R8: With a reload value of zero, the down-counter stays at zero and the event count increments on every prescaler tick.
- R9: Reset clears the LED, misc, debug, reload, down-counter, event count and both time counters to zero. Every counter starts counting from zero on release.
- R10: Buttons (and switches when present) pass through a two-flop synchroniser and read in the low bits with zeros above. A change becomes visible to a read requested on the third edge after it.
- R11: All counters are 32 bits wide and wrap modulo 2^32.
- R12: A write to the read-only button offset is ignored and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access request, one clock per access |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset within the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| busErr | output | 1 | One-clock pulse after an unmapped access |
| buttons | input | NUM_BTN | Asynchronous push-button levels |
| switches | input | NUM_SW | Asynchronous switch levels |
| leds | output | NUM_LEDS | Active-high LED drives |

## Verification
The assertions assume every bus input is a defined level at each clock edge, and that a request lasts exactly one clock, so that each `busSel` cycle is one access. They also assume the rates divide cleanly enough that one tick per clock is the most a counter sees. The bench only drives the bus at falling edges, with `busSel` raised for a single clock and lowered between requests. It keeps `CLK_HZ` at a value that 1 and 100 divide exactly, and it changes `buttons` only while no read of that offset is in flight.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_LED  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_DBG  = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_BTN  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_SLOW = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_FAST = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_EVC  = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_PRE  = 12'h01C;
  localparam logic [ADDR_W-1:0] OFF_PSC  = 12'h020;
  localparam logic [ADDR_W-1:0] OFF_SW   = 12'h028;
  localparam logic [ADDR_W-1:0] OFF_MISC = 12'h04C;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_LED, SEL_DBG, SEL_BTN, SEL_SLOW, SEL_FAST,
    SEL_EVC, SEL_PRE, SEL_PSC, SEL_SW, SEL_MISC
  } regSel_e;

  // strobes from decode control to the register datapath
  typedef struct packed {
    regSel_e rdSel;
    logic    rdEn;
    logic    bad;
    logic    wrLed;
    logic    wrDbg;
    logic    wrMisc;
    logic    wrSlow;
    logic    wrFast;
    logic    wrEvc;
    logic    wrPre;
    logic    wrPsc;
  } strobe_t;
endpackage

// File: rtl/sysctl_ratecnt.sv
`timescale 1ns/1ps
// Loadable counter advancing RATE times per CLK_HZ clocks via a phase accumulator.
module sysctl_ratecnt #(
  parameter int CLK_HZ = 25_000_000,
  parameter int RATE   = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        load,
  input  logic [31:0] wdata,
  output logic [31:0] count
);
  localparam int ACC_W = $clog2(CLK_HZ + RATE + 1);
  localparam logic [ACC_W-1:0] STEP = ACC_W'(RATE);
  localparam logic [ACC_W-1:0] LIM  = ACC_W'(CLK_HZ);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;

  assign sum = acc + STEP;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc   <= '0;
      count <= '0;
    end else if (load) begin
      acc   <= '0;
      count <= wdata;
    end else if (sum >= LIM) begin
      acc   <= sum - LIM;
      count <= count + 32'd1;
    end else begin
      acc   <= sum;
    end
  end
endmodule

// File: rtl/sysctl_evcnt.sv
`timescale 1ns/1ps
// Prescaled event counter: reload value, down-counter, event count.
module sysctl_evcnt #(
  parameter int PS_DIV = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrPre,
  input  logic        wrPsc,
  input  logic        wrEvc,
  input  logic [31:0] wdata,
  output logic [31:0] reload,
  output logic [31:0] downCnt,
  output logic [31:0] evCnt
);
  localparam int DIV_W = (PS_DIV > 1) ? $clog2(PS_DIV) : 1;

  logic psTick;

  generate
    if (PS_DIV <= 1) begin : gNoDiv
      assign psTick = 1'b1;
    end else begin : gDiv
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN) divCnt <= '0;
        else if (divCnt == DIV_W'(PS_DIV - 1)) divCnt <= '0;
        else divCnt <= divCnt + 1'b1;
      end
      assign psTick = (divCnt == DIV_W'(PS_DIV - 1));
    end
  endgenerate

  logic atZero;
  assign atZero = (downCnt == 32'd0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reload  <= '0;
      downCnt <= '0;
      evCnt   <= '0;
    end else begin
      if (wrPre) reload <= wdata;

      if (wrPsc)       downCnt <= wdata;
      else if (psTick) downCnt <= atZero ? reload : downCnt - 32'd1;

      if (wrEvc)                 evCnt <= wdata;
      else if (psTick && atZero) evCnt <= evCnt + 32'd1;
    end
  end
endmodule

// File: rtl/sysctl_ctrl.sv
`timescale 1ns/1ps
// Address decode: turns one bus request into datapath strobes.
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter bit HAS_DBG = 1'b0,
  parameter bit HAS_SW  = 1'b0
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);
  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_NONE;
    if (busSel) begin
      strb.rdEn = !busWr;
      case (busAddr)
        OFF_LED:  begin strb.rdSel = SEL_LED;  strb.wrLed  = busWr; end
        OFF_DBG: begin
          if (HAS_DBG) begin strb.rdSel = SEL_DBG; strb.wrDbg = busWr; end
          else strb.bad = 1'b1;
        end
        OFF_BTN:  strb.rdSel = SEL_BTN;
        OFF_SLOW: begin strb.rdSel = SEL_SLOW; strb.wrSlow = busWr; end
        OFF_FAST: begin strb.rdSel = SEL_FAST; strb.wrFast = busWr; end
        OFF_EVC:  begin strb.rdSel = SEL_EVC;  strb.wrEvc  = busWr; end
        OFF_PRE:  begin strb.rdSel = SEL_PRE;  strb.wrPre  = busWr; end
        OFF_PSC:  begin strb.rdSel = SEL_PSC;  strb.wrPsc  = busWr; end
        OFF_SW: begin
          if (HAS_SW) strb.rdSel = SEL_SW;
          else strb.bad = 1'b1;
        end
        OFF_MISC: begin strb.rdSel = SEL_MISC; strb.wrMisc = busWr; end
        default:  strb.bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/sysctl_dpath.sv
`timescale 1ns/1ps
// Register storage, counters, input synchronisers and read return path.
module sysctl_dpath
  import sysctl_pkg::*;
#(
  parameter int NUM_LEDS = 2,
  parameter int NUM_BTN  = 2,
  parameter int NUM_SW   = 8,
  parameter bit HAS_DBG  = 1'b0,
  parameter bit HAS_SW   = 1'b0,
  parameter int CLK_HZ   = 25_000_000,
  parameter int PS_DIV   = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_BTN-1:0]  buttons,
  input  logic [NUM_SW-1:0]   switches,
  output logic [NUM_LEDS-1:0] leds,
  output logic [DATA_W-1:0]   rdata,
  output logic                err
);
  logic [NUM_LEDS-1:0] ledReg;
  logic [DATA_W-1:0]   miscReg;
  logic [DATA_W-1:0]   dbgVal;
  logic [DATA_W-1:0]   swVal;
  logic [DATA_W-1:0]   slowCnt, fastCnt;
  logic [DATA_W-1:0]   reload, downCnt, evCnt;
  logic [NUM_BTN-1:0]  btnMeta, btnSync;
  logic [DATA_W-1:0]   rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ledReg  <= '0;
      miscReg <= '0;
      btnMeta <= '0;
      btnSync <= '0;
    end else begin
      if (strb.wrLed)  ledReg  <= wdata[NUM_LEDS-1:0];
      if (strb.wrMisc) miscReg <= wdata;
      btnMeta <= buttons;
      btnSync <= btnMeta;
    end
  end
  assign leds = ledReg;

  generate
    if (HAS_DBG) begin : gDbg
      logic [DATA_W-1:0] dbgReg;
      always_ff @(posedge clk) begin
        if (!rstN) dbgReg <= '0;
        else if (strb.wrDbg) dbgReg <= wdata;
      end
      assign dbgVal = dbgReg;
    end else begin : gNoDbg
      logic unusedDbg;
      assign unusedDbg = strb.wrDbg;
      assign dbgVal    = '0;
    end

    if (HAS_SW) begin : gSw
      logic [NUM_SW-1:0] swMeta, swSync;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          swMeta <= '0;
          swSync <= '0;
        end else begin
          swMeta <= switches;
          swSync <= swMeta;
        end
      end
      assign swVal = DATA_W'(swSync);
    end else begin : gNoSw
      logic unusedSw;
      assign unusedSw = ^switches;
      assign swVal    = '0;
    end
  endgenerate

  sysctl_ratecnt #(.CLK_HZ(CLK_HZ), .RATE(1)) slowInst (
    .clk(clk), .rstN(rstN), .load(strb.wrSlow), .wdata(wdata), .count(slowCnt));

  sysctl_ratecnt #(.CLK_HZ(CLK_HZ), .RATE(100)) fastInst (
    .clk(clk), .rstN(rstN), .load(strb.wrFast), .wdata(wdata), .count(fastCnt));

  sysctl_evcnt #(.PS_DIV(PS_DIV)) evInst (
    .clk(clk), .rstN(rstN), .wrPre(strb.wrPre), .wrPsc(strb.wrPsc), .wrEvc(strb.wrEvc),
    .wdata(wdata), .reload(reload), .downCnt(downCnt), .evCnt(evCnt));

  always_comb begin
    case (strb.rdSel)
      SEL_LED:  rdNext = DATA_W'(ledReg);
      SEL_DBG:  rdNext = dbgVal;
      SEL_BTN:  rdNext = DATA_W'(btnSync);
      SEL_SLOW: rdNext = slowCnt;
      SEL_FAST: rdNext = fastCnt;
      SEL_EVC:  rdNext = evCnt;
      SEL_PRE:  rdNext = reload;
      SEL_PSC:  rdNext = downCnt;
      SEL_SW:   rdNext = swVal;
      SEL_MISC: rdNext = miscReg;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      err <= strb.bad;
      if (strb.rdEn) rdata <= rdNext;
    end
  end
endmodule

// File: rtl/sysctl_regs.sv
`timescale 1ns/1ps
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int NUM_LEDS = 2,
  parameter int NUM_BTN  = 2,
  parameter int NUM_SW   = 8,
  parameter bit HAS_DBG  = 1'b0,
  parameter bit HAS_SW   = 1'b0,
  parameter int CLK_HZ   = 25_000_000,
  parameter int PS_DIV   = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWr,
  input  logic [11:0]         busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                busErr,
  input  logic [NUM_BTN-1:0]  buttons,
  input  logic [NUM_SW-1:0]   switches,
  output logic [NUM_LEDS-1:0] leds
);
  strobe_t strb;

  sysctl_ctrl #(.HAS_DBG(HAS_DBG), .HAS_SW(HAS_SW)) ctrlInst (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .strb(strb));

  sysctl_dpath #(
    .NUM_LEDS(NUM_LEDS), .NUM_BTN(NUM_BTN), .NUM_SW(NUM_SW), .HAS_DBG(HAS_DBG),
    .HAS_SW(HAS_SW), .CLK_HZ(CLK_HZ), .PS_DIV(PS_DIV)
  ) dpathInst (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata), .buttons(buttons),
    .switches(switches), .leds(leds), .rdata(busRdata), .err(busErr));
endmodule

// File: rtl/sysctl_regs_chk.sv
`timescale 1ns/1ps
module sysctl_regs_chk #(
  parameter bit HAS_DBG  = 1'b0,
  parameter bit HAS_SW   = 1'b0,
  parameter int NUM_LEDS = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                busSel,
  input logic                busWr,
  input logic [11:0]         busAddr,
  input logic [31:0]         busRdata,
  input logic                busErr,
  input logic [NUM_LEDS-1:0] leds
);
  logic hit;
  always_comb begin
    hit = (busAddr == 12'h000) || (busAddr == 12'h008) || (busAddr == 12'h010) ||
          (busAddr == 12'h014) || (busAddr == 12'h018) || (busAddr == 12'h01C) ||
          (busAddr == 12'h020) || (busAddr == 12'h04C) ||
          (HAS_DBG && busAddr == 12'h004) || (HAS_SW && busAddr == 12'h028);
  end

  assert_unmapped_read_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busWr && !hit |=> busRdata == 32'd0 && busErr);

  assert_mapped_no_err_R4: assert property (@(posedge clk) disable iff (!rstN)
    busSel && hit |=> !busErr);

  assert_idle_no_err_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |=> !busErr);

  assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWr) |=> $stable(busRdata));

  assert_led_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWr && busAddr == 12'h000) |=> $stable(leds));
endmodule

bind sysctl_regs sysctl_regs_chk #(.HAS_DBG(HAS_DBG), .HAS_SW(HAS_SW), .NUM_LEDS(NUM_LEDS))
  chkInst (.clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
           .busRdata(busRdata), .busErr(busErr), .leds(leds));

// File: tb/sysctl_regs_test.sv
`timescale 1ns/1ps
module sysctl_regs_test;
  localparam int LEDS = 3;
  localparam int BTNS = 2;
  localparam int SWS  = 4;
  localparam int HZ   = 1000;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            busSel = 1'b0, busWr = 1'b0;
  logic [11:0]     busAddr = '0;
  logic [31:0]     busWdata = '0;
  logic [31:0]     busRdata;
  logic            busErr;
  logic [BTNS-1:0] buttons = '0;
  logic [SWS-1:0]  switches = '1;
  logic [LEDS-1:0] leds;

  sysctl_regs #(.NUM_LEDS(LEDS), .NUM_BTN(BTNS), .NUM_SW(SWS), .HAS_DBG(1'b1),
                .HAS_SW(1'b0), .CLK_HZ(HZ), .PS_DIV(1)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr), .buttons(buttons),
    .switches(switches), .leds(leds));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= rstN ? cyc + 1 : 0;

  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d,
                          output int ed, output logic e);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d; ed = cyc + 1;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; e = busErr;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d,
                         output int ed, output logic e);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a; ed = cyc + 1;
    @(negedge clk);
    busSel = 1'b0; d = busRdata; e = busErr;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic longint incs(longint t, longint d, longint p);
    if (t <= d) return 0;
    return (t - d - 1) / (p + 1) + 1;
  endfunction

  function automatic longint downAt(longint t, longint d, longint p);
    if (t <= d) return d - t;
    return p - ((t - d - 1) % (p + 1));
  endfunction

  function automatic bit mapped(int a);
    return a == 'h00 || a == 'h04 || a == 'h08 || a == 'h10 || a == 'h14 ||
           a == 'h18 || a == 'h1C || a == 'h20 || a == 'h4C;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected=finished", cyc);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    int ew, ec, er;
    logic [31:0] miscLast;
    longint pv[5] = '{5, 0, 2, 3, 1};
    longint dv[5] = '{7, 3, 0, 2, 9};
    longint cv[5] = '{100, 0, 50, 32'hFFFF_FFF0, 9};

    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R9: reset state; live counters started from zero at release
    check("R9 leds", 32'(leds), 0);
    busRead(12'h018, d, er, e); check("R9 event count", d, 32'(er - 1));
    busRead(12'h014, d, er, e); check("R9 100Hz", d, 32'((er - 1) / 10));
    busRead(12'h010, d, er, e); check("R9 1Hz", d, 32'((er - 1) / HZ));
    busRead(12'h020, d, er, e); check("R9 down-counter", d, 0);
    busRead(12'h01C, d, er, e); check("R9 reload", d, 0);
    busRead(12'h000, d, er, e); check("R9 led reg", d, 0);
    busRead(12'h04C, d, er, e); check("R9 misc", d, 0);
    busRead(12'h004, d, er, e); check("R9 debug", d, 0);

    // R1 R3 R4: sweep every byte offset of the low map plus the window top
    for (int a = 0; a < 'h60; a++) begin
      busRead(12'(a), d, er, e);
      if (mapped(a)) check($sformatf("R1 mapped err @%0h", a), 32'(e), 0);
      else begin
        check($sformatf("R4 unmapped err @%0h", a), 32'(e), 1);
        check($sformatf("R4 unmapped data @%0h", a), d, 0);
      end
    end
    busRead(12'hFFC, d, er, e); check("R4 top err", 32'(e), 1);
    busRead(12'h028, d, er, e); check("R3 absent switch err", 32'(e), 1);
    check("R3 absent switch data", d, 0);
    busRead(12'h004, d, er, e); check("R3 present debug err", 32'(e), 0);

    // R2: LED masking to 3 bits
    for (int v = 0; v < 16; v++) begin
      logic [31:0] wd;
      wd = 32'hA5A5_A5A0 | 32'(v);
      busWrite(12'h000, wd, ew, e);
      check("R2 led pins", 32'(leds), 32'(wd[2:0]));
      busRead(12'h000, d, er, e);
      check("R2 led readback", d, 32'(wd[2:0]));
    end

    // R5: misc and debug read as written
    foreach (cv[i]) begin
      logic [31:0] p;
      p = 32'hDEAD_BEEF ^ 32'(cv[i] * 32'h0101_0101);
      busWrite(12'h04C, p, ew, e);
      busWrite(12'h004, ~p, ew, e);
      busRead(12'h04C, d, er, e); check("R5 misc", d, p);
      busRead(12'h004, d, er, e); check("R5 debug", d, ~p);
      miscLast = p;
    end

    // R4: writes to unmapped offsets flag and change nothing
    busWrite(12'h030, 32'h1234_5678, ew, e); check("R4 write err", 32'(e), 1);
    busWrite(12'h028, 32'hFFFF_FFFF, ew, e); check("R4 gated write err", 32'(e), 1);
    busWrite(12'h04D, 32'h0, ew, e); check("R4 misaligned write err", 32'(e), 1);
    busRead(12'h04C, d, er, e); check("R4 misc untouched", d, miscLast);
    check("R4 leds untouched", 32'(leds), 32'h7);
    busRead(12'h030, d, er, e); check("R4 unmapped still zero", d, 0);

    // R10 R12: synchronised buttons
    for (int b = 0; b < 4; b++) begin
      logic [31:0] old;
      old = 32'((b + 3) % 4);
      buttons = BTNS'(old);
      idle(4);
      buttons = BTNS'(b);
      busRead(12'h008, d, er, e); check("R10 button latency", d, old);
      busRead(12'h008, d, er, e); check("R10 button value", d, 32'(b));
      busWrite(12'h008, 32'hFFFF_FFFF, ew, e); check("R12 button write err", 32'(e), 0);
      busRead(12'h008, d, er, e); check("R12 button unchanged", d, 32'(b));
    end

    // R6: 100 Hz counter load and period
    busWrite(12'h014, 32'd500, ew, e);
    for (int w = 0; w < 40; w += 7) begin
      idle(w);
      busRead(12'h014, d, er, e);
      check("R6 100Hz", d, 32'(500 + (er - 1 - ew) / 10));
    end
    idle(6);
    busWrite(12'h014, 32'd20, ew, e);
    for (int w = 0; w < 5; w++) begin
      busRead(12'h014, d, er, e);
      check("R6 100Hz phase restart", d, 32'(20 + (er - 1 - ew) / 10));
    end
    busWrite(12'h010, 32'd7, ew, e);
    idle(990);
    busRead(12'h010, d, er, e); check("R6 1Hz before", d, 32'(7 + (er - 1 - ew) / HZ));
    idle(12);
    busRead(12'h010, d, er, e); check("R6 1Hz after", d, 32'(7 + (er - 1 - ew) / HZ));

    // R11: wrap of time and event counters
    busWrite(12'h014, 32'hFFFF_FFFF, ew, e);
    idle(25);
    busRead(12'h014, d, er, e);
    check("R11 100Hz wrap", d, 32'(64'hFFFF_FFFF + (er - 1 - ew) / 10));
    busWrite(12'h01C, 32'd0, ew, e);
    busWrite(12'h020, 32'd0, ew, e);
    busWrite(12'h018, 32'hFFFF_FFFE, ec, e);
    idle(3);
    busRead(12'h018, d, er, e);
    check("R11 event wrap", d,
          32'(64'hFFFF_FFFE + incs(er - 1 - ew, 0, 0) - incs(ec - ew, 0, 0)));

    // R7 R8: event counter under several reload/start values
    foreach (pv[i]) begin
      string tag;
      tag = (pv[i] == 0) ? "R8" : "R7";
      busWrite(12'h01C, 32'(pv[i]), ew, e);
      busWrite(12'h020, 32'(dv[i]), ew, e);
      busWrite(12'h018, 32'(cv[i]), ec, e);
      busRead(12'h01C, d, er, e); check({tag, " reload"}, d, 32'(pv[i]));
      for (int k = 0; k < 6; k++) begin
        idle(k * 3);
        busRead(12'h018, d, er, e);
        check({tag, " event count"}, d,
              32'(cv[i] + incs(er - 1 - ew, dv[i], pv[i]) - incs(ec - ew, dv[i], pv[i])));
        busRead(12'h020, d, er, e);
        check({tag, " down-counter"}, d, 32'(downAt(er - 1 - ew, dv[i], pv[i])));
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule